// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block gathers every interrupt source of a small hardwired network controller into one host-visible cause register and one active-low interrupt line. Three controller-wide events (own address seen in a foreign ARP request, an ICMP destination-unreachable reply during UDP sending, closure of a PPPoE session) are latched from single-cycle internal pulses. The host clears each one by writing a 1 to its bit. Each socket has its own 8-bit interrupt register, set by internal pulses and cleared by host write-1-to-clear. The cause register shows that register only as a one-bit summary, which the host cannot clear directly. When an unreachable event fires, the block also keeps the offending IPv4 address and port so the host can read them later.

The host reaches everything through a simple synchronous port: one address, a write strobe and write data, and read data that is registered one cycle after the address. An enable mask chooses which cause bits may pull the interrupt line low.

Top module: `net_irq_agg`

## Requirements
- R1: After reset the cause register (0x0015), the mask register (0x0016) and every socket register read 0x00, and `irq_n` is high.
- R2: A pulse on `ev_ip_conflict` sets cause bit 7. Writing 1 to bit 7 of 0x0015 clears it.
- R3: A pulse on `ev_unreach` sets cause bit 6 and, on the same edge, captures `unreach_ip` and `unreach_port`. The IP reads at 0x0030..0x0033 with the most significant byte first, and the port reads at 0x0034..0x0035 with the most significant byte first. A later event overwrites both. Writing 1 to bit 6 clears the cause bit.
- R4: A pulse on `ev_pppoe_close` sets cause bit 5. Writing 1 to bit 5 clears it.
- R5: Cause bit 4 always reads 0. Writes to bits 4..0 of 0x0015 have no effect.
- R6: Socket n's register sits at 0x0040+n. A set pulse on `sock_set[n*8+b]` sets its bit b, and writing 1 to a bit clears that bit.
- R7: Cause bit n (n = 0..3) reads 1 exactly while socket n's register is non-zero. It drops only once that register reaches 0x00.
- R8: When a set pulse and a host write-1-to-clear hit the same bit on the same edge, the bit ends up set. This holds for both event bits and socket bits.
- R9: The mask at 0x0016 can be read and written, with one enable per cause bit at the same position. `irq_n` is low while any enabled cause bit is set, and high once all enabled bits are clear.
- R10: `reg_rdata` shows, one cycle after an edge, the register addressed at that edge. Unmapped addresses read 0x00.
- R11: The captured unreachable IP and port registers are read-only. Host writes to 0x0030..0x0035 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| ev_ip_conflict | input | 1 | One-cycle pulse: own address seen as ARP sender |
| ev_unreach | input | 1 | One-cycle pulse: destination-unreachable reply received |
| unreach_ip | input | 32 | Offending IPv4 address, valid with `ev_unreach` |
| unreach_port | input | 16 | Offending port, valid with `ev_unreach` |
| ev_pppoe_close | input | 1 | One-cycle pulse: PPPoE session closed |
| sock_set | input | 32 | Per-socket set pulses, socket n in bits n*8+7..n*8 |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The assertions assume that event inputs are clean single-cycle pulses sampled on the rising edge. They also assume that `unreach_ip` and `unreach_port` are valid in the same cycle as `ev_unreach`, and that no input is unknown once reset is released. The stimulus drives all inputs to zero from time zero. It changes inputs only on the falling edge and holds each pulse for exactly one rising edge, so each pulse lands on exactly one edge. Collisions between setting and clearing are created on purpose, with both signals placed in the same cycle.

// File: rtl/net_irq_pkg.sv
// Package: shared constants for the interrupt aggregator.
// Assumes an 8-bit host data path; the cause-bit positions are fixed
// because host software decodes them.
package net_irq_pkg;
    localparam int DATA_W       = 8;
    localparam int BIT_CONFLICT = 7;
    localparam int BIT_UNREACH  = 6;
    localparam int BIT_PPPOE    = 5;
    localparam int BIT_RSVD     = 4;
    localparam int MAX_SOCK     = 4;
    typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/irq_evt_bit.sv
// Module: one latched event bit with host write-1-to-clear.
// Assumes set_i is a single-cycle pulse; when set and clear arrive together, set wins.
module irq_evt_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_q;

    // Purpose: hold the event until the host clears it; a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_q <= 1'b0;
        else if (set_i)  q_q <= 1'b1;
        else if (clr_i)  q_q <= 1'b0;
    end

    assign q_o = q_q;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/irq_sock_reg.sv
// Module: per-socket interrupt register with a pending summary.
// Assumes set_i carries single-cycle pulses per bit; a host write clears
// every bit written as 1, but a bit whose set pulse arrives in the same cycle stays set.
module irq_sock_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o,
    output logic         pend_o
);
    logic [W-1:0] q_q;
    logic [W-1:0] clr_mask;

    // Purpose: build the clear mask only when this register is written.
    always_comb clr_mask = wr_i ? wdata_i : '0;

    // Purpose: set bits from pulses and clear bits from host writes; a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= (q_q & ~clr_mask) | set_i;
    end

    assign q_o    = q_q;
    assign pend_o = |q_q;

    assert_sock_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (set_i == '0)) |=> ((q_o & $past(wdata_i)) == '0));
    assert_sock_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
    assert_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> pend_o);
endmodule

// File: rtl/irq_unreach_cap.sv
// Module: capture of the unreachable destination address and port.
// Assumes ip_i and port_i are valid in the cycle cap_i is high; host writes never reach this module.
module irq_unreach_cap #(
    parameter int IP_W   = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [IP_W-1:0]   ip_i,
    input  logic [PORT_W-1:0] port_i,
    output logic [IP_W-1:0]   ip_o,
    output logic [PORT_W-1:0] port_o
);
    logic [IP_W-1:0]   ip_q;
    logic [PORT_W-1:0] port_q;

    // Purpose: overwrite the stored address and port on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q   <= '0;
            port_q <= '0;
        end else if (cap_i) begin
            ip_q   <= ip_i;
            port_q <= port_i;
        end
    end

    assign ip_o   = ip_q;
    assign port_o = port_q;

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (ip_o == $past(ip_i) && port_o == $past(port_i)));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(ip_o) && $stable(port_o)));
endmodule

// File: rtl/net_irq_agg.sv
// Module: interrupt cause register, enable mask, per-socket registers,
// unreachable capture and the host register port.
// Assumes NUM_SOCK <= 4 and byte-wide host access; read data is registered.
module net_irq_agg
    import net_irq_pkg::*;
#(
    parameter int ADDR_W          = 16,
    parameter int NUM_SOCK        = 4,
    parameter int SOCK_W          = 8,
    parameter int IP_W            = 32,
    parameter int PORT_W          = 16,
    parameter int ADDR_CAUSE      = 16'h0015,
    parameter int ADDR_MASK       = 16'h0016,
    parameter int ADDR_UIP_BASE   = 16'h0030,
    parameter int ADDR_UPORT_BASE = 16'h0034,
    parameter int ADDR_SOCK_BASE  = 16'h0040
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic                       ev_ip_conflict,
    input  logic                       ev_unreach,
    input  logic [IP_W-1:0]            unreach_ip,
    input  logic [PORT_W-1:0]          unreach_port,
    input  logic                       ev_pppoe_close,
    input  logic [NUM_SOCK*SOCK_W-1:0] sock_set,
    output logic                       irq_n
);
    localparam int IP_BYTES   = IP_W / DATA_W;
    localparam int PORT_BYTES = PORT_W / DATA_W;

    logic                     wr_cause;
    logic                     wr_mask;
    logic [DATA_W-1:0]        mask_q;
    logic [DATA_W-1:0]        cause;
    logic                     evt_conflict;
    logic                     evt_unreach;
    logic                     evt_pppoe;
    logic [MAX_SOCK-1:0]      sock_pend;
    logic [SOCK_W-1:0]        sock_q [NUM_SOCK];
    logic [IP_W-1:0]          uip;
    logic [PORT_W-1:0]        uport;
    logic [DATA_W-1:0]        rd_mux;
    logic [DATA_W-1:0]        rdata_q;

    // Purpose: decode host writes to the cause and mask registers.
    always_comb begin
        wr_cause = reg_wr && (reg_addr == ADDR_W'(ADDR_CAUSE));
        wr_mask  = reg_wr && (reg_addr == ADDR_W'(ADDR_MASK));
    end

    irq_evt_bit u_conflict (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_ip_conflict),
        .clr_i (wr_cause && reg_wdata[BIT_CONFLICT]),
        .q_o   (evt_conflict)
    );

    irq_evt_bit u_unreach (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_unreach),
        .clr_i (wr_cause && reg_wdata[BIT_UNREACH]),
        .q_o   (evt_unreach)
    );

    irq_evt_bit u_pppoe (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_pppoe_close),
        .clr_i (wr_cause && reg_wdata[BIT_PPPOE]),
        .q_o   (evt_pppoe)
    );

    irq_unreach_cap #(.IP_W(IP_W), .PORT_W(PORT_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (ev_unreach),
        .ip_i   (unreach_ip),
        .port_i (unreach_port),
        .ip_o   (uip),
        .port_o (uport)
    );

    for (genvar n = 0; n < MAX_SOCK; n++) begin : g_sock
        if (n < NUM_SOCK) begin : g_used
            irq_sock_reg #(.W(SOCK_W)) u_sock (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_i   (sock_set[n*SOCK_W +: SOCK_W]),
                .wr_i    (reg_wr && (reg_addr == ADDR_W'(ADDR_SOCK_BASE + n))),
                .wdata_i (reg_wdata[SOCK_W-1:0]),
                .q_o     (sock_q[n]),
                .pend_o  (sock_pend[n])
            );
        end else begin : g_unused
            assign sock_pend[n] = 1'b0;
        end
    end

    // Purpose: hold the interrupt enable mask written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata;
    end

    // Purpose: assemble the cause register; the reserved bit is tied low.
    always_comb begin
        cause               = '0;
        cause[BIT_CONFLICT] = evt_conflict;
        cause[BIT_UNREACH]  = evt_unreach;
        cause[BIT_PPPOE]    = evt_pppoe;
        cause[BIT_RSVD]     = 1'b0;
        cause[MAX_SOCK-1:0] = sock_pend;
    end

    // Purpose: drive the interrupt line low while any enabled cause is pending.
    assign irq_n = ~|(cause & mask_q);

    // Purpose: select the addressed register for readback; unmapped reads 0.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(ADDR_CAUSE)) rd_mux = cause;
        if (reg_addr == ADDR_W'(ADDR_MASK))  rd_mux = mask_q;
        for (int i = 0; i < IP_BYTES; i++) begin
            if (reg_addr == ADDR_W'(ADDR_UIP_BASE + i))
                rd_mux = uip[(IP_BYTES-1-i)*DATA_W +: DATA_W];
        end
        for (int i = 0; i < PORT_BYTES; i++) begin
            if (reg_addr == ADDR_W'(ADDR_UPORT_BASE + i))
                rd_mux = uport[(PORT_BYTES-1-i)*DATA_W +: DATA_W];
        end
        for (int n = 0; n < NUM_SOCK; n++) begin
            if (reg_addr == ADDR_W'(ADDR_SOCK_BASE + n))
                rd_mux = DATA_W'(sock_q[n]);
        end
    end

    // Purpose: register read data for a one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ip_conflict && mask_q[BIT_CONFLICT] && !wr_mask) |=> !irq_n);
    assert_mask_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && !wr_mask) |=> irq_n);
    assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADDR_CAUSE)) |=> !reg_rdata[BIT_RSVD]);
    assert_cause_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause && sock_set == '0) |=> $stable(sock_pend));
endmodule

// File: tb/net_irq_agg_tb.sv
module net_irq_agg_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ev_ip_conflict = 1'b0;
    logic        ev_unreach = 1'b0;
    logic [31:0] unreach_ip = '0;
    logic [15:0] unreach_port = '0;
    logic        ev_pppoe_close = 1'b0;
    logic [31:0] sock_set = '0;
    logic        irq_n;

    typedef struct {
        bit       is_irq;
        logic [7:0] exp;
        int       due;
        string    tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    net_irq_agg u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_addr       (reg_addr),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .ev_ip_conflict (ev_ip_conflict),
        .ev_unreach     (ev_unreach),
        .unreach_ip     (unreach_ip),
        .unreach_port   (unreach_port),
        .ev_pppoe_close (ev_pppoe_close),
        .sock_set       (sock_set),
        .irq_n          (irq_n)
    );

    // Monitor: pop due items and compare with the outputs.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t it;
            logic [7:0] act;
            it = exp_q.pop_front();
            act = it.is_irq ? {7'd0, irq_n} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        ev_ip_conflict = 1'b0;
        ev_unreach = 1'b0;
        ev_pppoe_close = 1'b0;
        sock_set = '0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.due = cyc + 1; it.tag = tag;
        exp_q.push_back(it);
        tick();
    endtask

    task automatic chk_irq(input logic e, input string tag);
        exp_t it;
        it.is_irq = 1'b1; it.exp = {7'd0, e}; it.due = cyc + 1; it.tag = tag;
        exp_q.push_back(it);
        tick();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(16'h0015, 8'h00, "R1 cause after reset");
        rd(16'h0016, 8'h00, "R1 mask after reset");
        rd(16'h0042, 8'h00, "R1 socket2 after reset");
        chk_irq(1'b1, "R1 irq_n high after reset");
        // R9 mask access
        wr(16'h0016, 8'hFF);
        rd(16'h0016, 8'hFF, "R9 mask readback");
        chk_irq(1'b1, "R9 no cause no irq");
        // R2 conflict
        ev_ip_conflict = 1'b1; tick();
        rd(16'h0015, 8'h80, "R2 conflict set");
        chk_irq(1'b0, "R9 irq low on enabled cause");
        wr(16'h0015, 8'h80);
        rd(16'h0015, 8'h00, "R2 conflict cleared");
        chk_irq(1'b1, "R9 irq high when clear");
        // R3 unreachable capture
        ev_unreach = 1'b1; unreach_ip = 32'hC0A80107; unreach_port = 16'h1F90; tick();
        unreach_ip = 32'hDEADBEEF; unreach_port = 16'hBEEF;
        rd(16'h0015, 8'h40, "R3 unreach set");
        rd(16'h0030, 8'hC0, "R3 ip byte0");
        rd(16'h0031, 8'hA8, "R3 ip byte1");
        rd(16'h0032, 8'h01, "R3 ip byte2");
        rd(16'h0033, 8'h07, "R3 ip byte3");
        rd(16'h0034, 8'h1F, "R3 port high");
        rd(16'h0035, 8'h90, "R3 port low");
        // R11 read-only capture
        wr(16'h0030, 8'h55);
        wr(16'h0035, 8'h55);
        rd(16'h0030, 8'hC0, "R11 ip not writable");
        rd(16'h0035, 8'h90, "R11 port not writable");
        ev_unreach = 1'b1; unreach_ip = 32'h0A000001; unreach_port = 16'h0035; tick();
        rd(16'h0030, 8'h0A, "R3 ip overwritten");
        rd(16'h0033, 8'h01, "R3 ip low overwritten");
        rd(16'h0035, 8'h35, "R3 port overwritten");
        wr(16'h0015, 8'h40);
        rd(16'h0015, 8'h00, "R3 unreach cleared");
        // R4 pppoe
        ev_pppoe_close = 1'b1; tick();
        rd(16'h0015, 8'h20, "R4 pppoe set");
        wr(16'h0015, 8'h20);
        rd(16'h0015, 8'h00, "R4 pppoe cleared");
        // R5 low bits ignored
        wr(16'h0015, 8'h1F);
        rd(16'h0015, 8'h00, "R5 write low bits no set");
        // R6 R7 sockets
        sock_set[2*8 +: 8] = 8'h03; tick();
        rd(16'h0042, 8'h03, "R6 socket2 bits set");
        rd(16'h0015, 8'h04, "R7 socket2 summary");
        wr(16'h0015, 8'h04);
        rd(16'h0015, 8'h04, "R5 socket bit not host clearable");
        wr(16'h0042, 8'h01);
        rd(16'h0042, 8'h02, "R6 socket2 partial clear");
        rd(16'h0015, 8'h04, "R7 summary stays while nonzero");
        wr(16'h0042, 8'h02);
        rd(16'h0042, 8'h00, "R6 socket2 cleared");
        rd(16'h0015, 8'h00, "R7 summary drops at zero");
        // R8 set wins
        ev_ip_conflict = 1'b1; reg_addr = 16'h0015; reg_wdata = 8'h80; reg_wr = 1'b1; tick();
        rd(16'h0015, 8'h80, "R8 event set beats clear");
        wr(16'h0015, 8'h80);
        sock_set[1*8 +: 8] = 8'h01; reg_addr = 16'h0041; reg_wdata = 8'h01; reg_wr = 1'b1; tick();
        rd(16'h0041, 8'h01, "R8 socket set beats clear");
        wr(16'h0041, 8'h01);
        rd(16'h0015, 8'h00, "R8 all cleared");
        // R9 selective mask
        wr(16'h0016, 8'h08);
        ev_pppoe_close = 1'b1; tick();
        rd(16'h0015, 8'h20, "R9 masked cause still visible");
        chk_irq(1'b1, "R9 masked cause no irq");
        sock_set[3*8 +: 8] = 8'h80; tick();
        chk_irq(1'b0, "R9 enabled socket3 irq");
        wr(16'h0043, 8'h80);
        chk_irq(1'b1, "R9 irq released after socket3 clear");
        wr(16'h0015, 8'h20);
        // R10 unmapped
        rd(16'h0000, 8'h00, "R10 unmapped reads zero");
        rd(16'h0016, 8'h08, "R10 mask read latency");
        repeat (3) tick();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule